// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. The frame shape comes from a small set of line-control inputs:

- character length;
- whether a parity bit is sent;
- the parity sense;
- a forced-parity option;
- the number of stop bits;
- a break override that pulls the line low.

Bit timing is driven by an externally supplied enable that pulses at sixteen times the baud rate.

A character is offered with a valid/ready handshake and is held in a one-deep pending slot. The next frame starts on the first baud tick when the shifter is free. When the previous frame ends on a tick and a character is pending, the new frame starts on that same tick, so frames run back to back. The control inputs are captured when a frame starts, so software may change them while a frame is on the line.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, `txd` is 1, `busy` is 0, `inReady` is 1 and `txEmpty` is 1 (the last only when no character is pending).
- R2: `lenSel` selects the number of data bits: 00 sends 5, 01 sends 6, 10 sends 7, 11 sends 8. Each frame begins with one 0 start bit, and the data follows least significant bit first.
- R3: Each bit slot lasts 16 `tickEn` pulses. A frame starts only on a `tickEn` pulse.
- R4: When `parityOn` is 0, no parity slot is sent, and `paritySense` and `parityStick` have no effect on `txd`.
- R5: When `parityOn` is 1 and `parityStick` is 0, the parity slot follows the data bits. Its value gives even parity over the data bits when `paritySense` is 1, and odd parity when it is 0.
- R6: When `parityOn` is 1 and `parityStick` is 1, the parity slot carries the inverse of `paritySense`.
- R7: When `twoStop` is 0, one stop bit (level 1) is sent. When it is 1, two full stop bits are sent, except with 5-bit characters, where the second stop slot lasts 8 ticks.
- R8: While `breakOn` is 1, `txd` is 0. The serializer keeps its timing underneath, so the bits after the break is released are those the frame would have sent anyway.
- R9: The length, parity, stop and data values are captured on the tick that starts a frame. Later changes to them affect only later frames.
- R10: `txEmpty` is 1 only when no character is pending and no frame is in progress. `busy` is 1 from the starting tick until the last stop slot ends.
- R11: `inReady` is 0 while a character is pending. A character is accepted on a clock edge where `inValid` and `inReady` are both 1. A pending character starts at the end of the running frame, on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Enable pulse at 16x the baud rate |
| inData | input | 8 | Character to send |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Pending slot is free |
| lenSel | input | 2 | Data length code: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8 |
| parityOn | input | 1 | Send a parity slot |
| paritySense | input | 1 | 1 = even parity, 0 = odd parity |
| parityStick | input | 1 | Parity slot forced to the inverse of paritySense |
| twoStop | input | 1 | Two stop slots (1.5 for 5-bit characters) |
| breakOn | input | 1 | Force txd low |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| txEmpty | output | 1 | Nothing pending and shifter idle |

## Verification
The assertions check the following on every cycle:

- break holds the line low;
- an idle line sits high;
- the tick counter freezes between ticks;
- a frame begins only on a tick, and only by taking the pending character;
- the data slot index stays within the selected length;
- a parity slot appears only in frames that captured parity enable;
- the half stop slot never runs past 8 ticks;
- the controller's take and load strobes agree with the pending flag.

The actual bit values and slot durations are shown only by the bench's scenarios. These cover every length, each parity mode, the stop-bit variants, a break inserted mid-frame, controls changed mid-frame and back-to-back characters. In each, a behavioural model predicts the line and the flags on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } txState_t;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic take;   // accept offered character into pending slot
    logic load;   // move pending character into shifter, capture framing
    logic shift;  // advance to next data bit
  } dpStrobe_t;

  typedef struct packed {
    logic [1:0] len;
    logic       parOn;
    logic       parSense;
    logic       parStick;
    logic       twoStop;
  } lineCfg_t;
endpackage

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CHAR_W-1:0] inData,
  input  lineCfg_t          cfgIn,
  output logic              pending,
  output lineCfg_t          cfgLat,
  output logic              shiftBit,
  output logic              parBit
);
  logic [CHAR_W-1:0] holdData;
  logic [CHAR_W-1:0] shiftReg;
  logic [CHAR_W-1:0] maskedHold;
  logic              rawPar;
  logic              newPar;

  always_comb begin
    maskedHold = holdData & ({CHAR_W{1'b1}} >> (2'd3 - cfgIn.len));
    rawPar     = ^maskedHold;
    if (cfgIn.parStick) newPar = ~cfgIn.parSense;
    else                newPar = cfgIn.parSense ? rawPar : ~rawPar;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      holdData <= '0;
      shiftReg <= '0;
      cfgLat   <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.take) begin
        holdData <= inData;
        pending  <= 1'b1;
      end
      if (strb.load) begin
        pending  <= 1'b0;
        shiftReg <= holdData;
        cfgLat   <= cfgIn;
        parBit   <= newPar;
      end else if (strb.shift) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  assign shiftBit = shiftReg[0];

  p_take_when_free_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> !pending);
  p_load_needs_char_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> pending);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      inValid,
  input  logic      pending,
  input  lineCfg_t  cfgLat,
  input  logic      shiftBit,
  input  logic      parBit,
  output dpStrobe_t strb,
  output logic      lineBit,
  output logic      busy
);
  localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT / 2 - 1);

  txState_t         state, nextState;
  logic [CNT_W-1:0] tickCnt, limit;
  logic [2:0]       bitIdx, lastIdx;
  logic             bitEnd, frameEnd, startNow;

  always_comb begin
    lastIdx = 3'd4 + {1'b0, cfgLat.len};
    limit   = (state == ST_STOP2 && cfgLat.len == 2'b00) ? HALF_LAST : FULL_LAST;
    bitEnd  = tickEn && (state != ST_IDLE) && (tickCnt == limit);
    nextState = state;
    frameEnd  = 1'b0;
    unique case (state)
      ST_IDLE:   ;
      ST_START:  if (bitEnd) nextState = ST_DATA;
      ST_DATA:   if (bitEnd && bitIdx == lastIdx)
                   nextState = cfgLat.parOn ? ST_PARITY : ST_STOP1;
      ST_PARITY: if (bitEnd) nextState = ST_STOP1;
      ST_STOP1:  if (bitEnd) begin
                   if (cfgLat.twoStop) nextState = ST_STOP2;
                   else                frameEnd  = 1'b1;
                 end
      ST_STOP2:  if (bitEnd) frameEnd = 1'b1;
      default:   nextState = ST_IDLE;
    endcase
    startNow = tickEn && pending && (state == ST_IDLE || frameEnd);
    if (frameEnd) nextState = ST_IDLE;
    if (startNow) nextState = ST_START;
    strb.load  = startNow;
    strb.shift = (state == ST_DATA) && bitEnd;
    strb.take  = inValid && !pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state <= nextState;
      if (startNow || bitEnd)            tickCnt <= '0;
      else if (tickEn && state != ST_IDLE) tickCnt <= tickCnt + 1'b1;
      if (startNow)        bitIdx <= '0;
      else if (strb.shift) bitIdx <= bitIdx + 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      ST_START:  lineBit = 1'b0;
      ST_DATA:   lineBit = shiftBit;
      ST_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  assign busy = (state != ST_IDLE);

  p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tickCnt));
  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (nextState == ST_START && state != ST_START) |-> tickEn && pending);
  p_data_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> bitIdx <= lastIdx);
  p_parity_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARITY) |-> cfgLat.parOn);
  p_half_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP2 && cfgLat.len == 2'b00) |-> tickCnt <= HALF_LAST);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  input  logic [1:0] lenSel,
  input  logic       parityOn,
  input  logic       paritySense,
  input  logic       parityStick,
  input  logic       twoStop,
  input  logic       breakOn,
  output logic       txd,
  output logic       busy,
  output logic       txEmpty
);
  dpStrobe_t strb;
  lineCfg_t  cfgIn, cfgLat;
  logic      pending, shiftBit, parBit, lineBit;

  assign cfgIn = '{len: lenSel, parOn: parityOn, parSense: paritySense,
                   parStick: parityStick, twoStop: twoStop};

  sertx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inValid(inValid),
    .pending(pending), .cfgLat(cfgLat), .shiftBit(shiftBit), .parBit(parBit),
    .strb(strb), .lineBit(lineBit), .busy(busy)
  );

  sertx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .cfgIn(cfgIn),
    .pending(pending), .cfgLat(cfgLat), .shiftBit(shiftBit), .parBit(parBit)
  );

  // break acts on the pin only; serializer state is untouched
  assign txd     = lineBit & ~breakOn;
  assign inReady = ~pending;
  assign txEmpty = ~busy & ~pending;

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |-> !txd);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !breakOn) |-> txd);
  p_empty_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(inValid));
  p_start_takes_pending_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $rose(inReady));
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] lenSel = 2'b11;
  logic       parityOn = 1'b0, paritySense = 1'b0, parityStick = 1'b0;
  logic       twoStop = 1'b0, breakOn = 1'b0;
  logic       txd, busy, txEmpty;

  int    errCnt = 0, chkCnt = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inData(inData), .inValid(inValid),
    .inReady(inReady), .lenSel(lenSel), .parityOn(parityOn),
    .paritySense(paritySense), .parityStick(parityStick), .twoStop(twoStop),
    .breakOn(breakOn), .txd(txd), .busy(busy), .txEmpty(txEmpty)
  );

  // 16x tick every fourth clock
  int tickDiv = 0;
  always @(posedge clk) begin
    #1;
    if (!rstN) begin tickDiv = 0; tickEn = 1'b0; end
    else begin tickDiv = (tickDiv + 1) % 4; tickEn = (tickDiv == 0); end
  end

  // behavioural reference: one queue entry per tick period of line level
  int   tq[$];
  bit   mPend = 0, mBusy = 0;
  int   mCur = 1;
  logic [7:0] mData = '0;

  function automatic void pushLevel(int lvl, int n);
    for (int k = 0; k < n; k++) tq.push_back(lvl);
  endfunction

  function automatic void buildFrame(logic [7:0] d);
    int nBits = 5 + int'(lenSel);
    int ones = 0;
    int p;
    pushLevel(0, 16);
    for (int i = 0; i < nBits; i++) begin
      pushLevel(int'(d[i]), 16);
      ones += int'(d[i]);
    end
    if (parityOn) begin
      if (parityStick) p = paritySense ? 0 : 1;
      else if (paritySense) p = ones % 2;        // even
      else p = (ones % 2 == 0) ? 1 : 0;           // odd
      pushLevel(p, 16);
    end
    pushLevel(1, 16);
    if (twoStop) pushLevel(1, (nBits == 5) ? 8 : 16);
  endfunction

  always @(posedge clk) begin
    bit oldPend;
    if (!rstN) begin
      tq.delete(); mPend = 0; mBusy = 0; mCur = 1;
    end else begin
      oldPend = mPend;
      if (tickEn) begin
        if (tq.size() == 0 && oldPend) begin buildFrame(mData); mPend = 0; end
        if (tq.size() > 0) begin mCur = tq.pop_front(); mBusy = 1; end
        else begin mCur = 1; mBusy = 0; end
      end
      if (inValid && !oldPend) begin mPend = 1; mData = inData; end
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(txd,     breakOn ? 1'b0 : mCur[0], "txd");
      chk(busy,    mBusy,                    "busy");
      chk(txEmpty, !mBusy && !mPend,         "txEmpty");
      chk(inReady, !mPend,                   "inReady");
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic sendChar(input logic [7:0] d);
    inData = d; inValid = 1'b1;
    while (1) begin
      if (inReady) begin @(posedge clk); #1; break; end
      @(posedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  task automatic waitEmpty();
    while (!txEmpty) begin @(posedge clk); #1; end
    cyc(10);
  endtask

  task automatic setCfg(input logic [1:0] l, input logic po, input logic ps,
                        input logic pk, input logic ts);
    lenSel = l; parityOn = po; paritySense = ps; parityStick = pk; twoStop = ts;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired in %s", curReq);
    finishRun();
  end

  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(20);
    // R1: reset values at the pins
    chk(txd, 1'b1, "reset txd");
    chk(busy, 1'b0, "reset busy");
    chk(txEmpty, 1'b1, "reset txEmpty");
    chk(inReady, 1'b1, "reset inReady");

    curReq = "R2";
    setCfg(2'b11, 0, 0, 0, 0); sendChar(8'hA5); waitEmpty();
    setCfg(2'b00, 0, 0, 0, 0); sendChar(8'hFF); waitEmpty();
    setCfg(2'b01, 0, 0, 0, 0); sendChar(8'h2A); waitEmpty();
    setCfg(2'b10, 0, 0, 0, 0); sendChar(8'hD3); waitEmpty();

    curReq = "R3";
    setCfg(2'b11, 0, 0, 0, 0); sendChar(8'h01); waitEmpty();

    curReq = "R4";
    setCfg(2'b11, 0, 1, 1, 0); sendChar(8'h37); waitEmpty();
    setCfg(2'b10, 0, 0, 1, 0); sendChar(8'h37); waitEmpty();

    curReq = "R5";
    setCfg(2'b11, 1, 1, 0, 0); sendChar(8'h07); waitEmpty();
    setCfg(2'b11, 1, 0, 0, 0); sendChar(8'h07); waitEmpty();
    setCfg(2'b01, 1, 1, 0, 0); sendChar(8'hC3); waitEmpty();
    setCfg(2'b00, 1, 0, 0, 0); sendChar(8'h00); waitEmpty();

    curReq = "R6";
    setCfg(2'b11, 1, 0, 1, 0); sendChar(8'h07); waitEmpty();
    setCfg(2'b11, 1, 1, 1, 0); sendChar(8'h06); waitEmpty();

    curReq = "R7";
    setCfg(2'b11, 0, 0, 0, 1); sendChar(8'h55); waitEmpty();
    setCfg(2'b00, 1, 1, 0, 1); sendChar(8'h15); waitEmpty();
    setCfg(2'b01, 0, 0, 0, 1); sendChar(8'h3C); waitEmpty();

    curReq = "R8";
    setCfg(2'b11, 1, 1, 0, 0); sendChar(8'h9B);
    cyc(150); breakOn = 1'b1; cyc(200); breakOn = 1'b0;
    waitEmpty();
    breakOn = 1'b1; cyc(30); breakOn = 1'b0; cyc(10);

    curReq = "R9";
    setCfg(2'b11, 1, 1, 0, 1); sendChar(8'hE1);
    cyc(120); setCfg(2'b00, 0, 0, 1, 0);
    waitEmpty();

    curReq = "R10";
    setCfg(2'b10, 0, 0, 0, 0);
    sendChar(8'h11); sendChar(8'h22);
    curReq = "R11";
    sendChar(8'h33);
    waitEmpty();
    sendChar(8'h44); cyc(2); sendChar(8'h5A);
    waitEmpty();

    finishRun();
  end
endmodule